// File: doc/BRIEF.md
# Pipeline Advance Controller with Store-Buffer Gating

This block steps a small, fixed set of in-flight instructions through a short memory pipeline, one decision per slot per clock. Each slot holds a valid bit, an opcode class (load or store), a pipeline stage and a remaining-latency count. On every edge a slot counts its latency down, moves to its next stage, or stalls. Every slot is updated at once from one snapshot of the current state.

Whether a slot may move depends on three things: the readiness rules of its own stage, whether its target stage is free, and a three-valued store-buffer status input. A load leaving the shared load/store stage needs the buffer drained and the store stage idle. A store sitting in the store stage needs only spare buffer space. A load port per slot lets the surrounding logic install an instruction or clear a slot. The per-slot advance flags are combinational outputs for the current cycle.

Stages and transitions: FETCH (code 0) goes to SHARED (code 3). From SHARED a load goes to LOAD (code 1) and a store goes to STORE (code 2). LOAD and STORE both go to RETIRED (code 4). RETIRED is terminal.

Top module: `pac_ctrl`

## Requirements
- R1: The buffer status is decoded as 2'b00 empty, 2'b01 partly filled and 2'b10 full. The unused code 2'b11 is treated exactly like full.
- R2: A valid slot with nonzero latency and no load pending decrements its latency by one, keeps its stage, and has its advance flag low.
- R3: A load (opcode 0) in SHARED with latency zero is ready only when the buffer status is 2'b00 and no valid slot is in STORE.
- R4: Any valid slot in STORE with latency zero is ready only when the buffer status is 2'b00 or 2'b01.
- R5: A valid slot with latency zero in FETCH or LOAD, or a store (opcode 1) in SHARED, is ready unconditionally. A slot in RETIRED is never ready and stays there.
- R6: A ready slot advances exactly when its target stage is free. A target is free when every valid slot in it is itself ready this cycle, which includes having no valid occupant. RETIRED as a target is always free.
- R7: An advancing slot takes its next stage from the table above (load 0: FETCH→SHARED→LOAD→RETIRED; store 1: FETCH→SHARED→STORE→RETIRED). Its latency stays zero.
- R8: When a slot's load enable is high, the slot takes the loaded valid bit, opcode, stage and latency on the next edge, whatever its advance decision.
- R9: Without a load, a valid slot's stage rank never decreases from one cycle to the next. The ranks are FETCH 0, SHARED 1, LOAD/STORE 2, RETIRED 3.
- R10: A synchronous reset clears every slot's valid bit.
- R11: An invalid slot never advances, and it stays invalid until it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | NSLOT | Per-slot load strobe |
| ld_valid | input | NSLOT | Valid bit to load |
| ld_store | input | NSLOT | Opcode to load: 0 load, 1 store |
| ld_stage | input | 3*NSLOT | Stage code to load, 3 bits per slot |
| ld_lat | input | LAT_W*NSLOT | Latency to load |
| sb_status | input | 2 | Store-buffer status |
| slot_valid | output | NSLOT | Current valid bits |
| slot_store | output | NSLOT | Current opcodes |
| slot_stage | output | 3*NSLOT | Current stage codes |
| slot_lat | output | LAT_W*NSLOT | Current latencies |
| slot_adv | output | NSLOT | Slot advances on the coming edge |

## Verification
The hardest cases to reach are the mutual dependencies between slots. A load in SHARED can be held back by a store parked in STORE while the buffer reads empty. A target stage can be freed only because its occupant is itself ready to leave. Running the pipeline from its ports rarely produces these. The stimulus therefore uses the load port to place all four slots directly into every combination of stage, opcode and validity, with some latencies nonzero, under each buffer status. It then compares one step against an arithmetic model, and directed sequences follow a single instruction through its latency and stalls.

// File: rtl/pac_pkg.sv
package pac_pkg;
    localparam int STAGE_W = 3;

    typedef enum logic [STAGE_W-1:0] {
        STG_FETCH   = 3'd0,
        STG_LOAD    = 3'd1,
        STG_STORE   = 3'd2,
        STG_SHARED  = 3'd3,
        STG_RETIRED = 3'd4
    } stage_e;

    typedef enum logic [1:0] {
        SB_EMPTY   = 2'd0,
        SB_PARTIAL = 2'd1,
        SB_FULL    = 2'd2,
        SB_RSVD    = 2'd3
    } sb_e;

    // Transition table: stage and opcode class give the next stage.
    function automatic stage_e next_stage(stage_e s, logic is_store);
        stage_e n;
        unique case (s)
            STG_FETCH:  n = STG_SHARED;
            STG_SHARED: n = is_store ? STG_STORE : STG_LOAD;
            STG_LOAD,
            STG_STORE:  n = STG_RETIRED;
            default:    n = STG_RETIRED;
        endcase
        return n;
    endfunction

    // Progress order, independent of the code values.
    function automatic logic [1:0] stage_rank(stage_e s);
        logic [1:0] r;
        unique case (s)
            STG_FETCH:  r = 2'd0;
            STG_SHARED: r = 2'd1;
            STG_LOAD,
            STG_STORE:  r = 2'd2;
            default:    r = 2'd3;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pac_ready.sv
module pac_ready
    import pac_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             valid,
    input  logic             is_store,
    input  stage_e           stage,
    input  logic [LAT_W-1:0] lat,
    input  sb_e              sb,
    input  logic             su_busy,
    output logic             ready
);
    logic sb_drained;
    logic sb_room;

    assign sb_drained = (sb == SB_EMPTY);
    assign sb_room    = (sb == SB_EMPTY) || (sb == SB_PARTIAL);

    always_comb begin
        ready = 1'b0;
        if (valid && lat == '0) begin
            unique case (stage)
                STG_SHARED: ready = is_store ? 1'b1 : (sb_drained && !su_busy);
                STG_STORE:  ready = sb_room;
                STG_FETCH,
                STG_LOAD:   ready = 1'b1;
                default:    ready = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pac_slot.sv
module pac_slot
    import pac_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_valid,
    input  logic             ld_store,
    input  stage_e           ld_stage,
    input  logic [LAT_W-1:0] ld_lat,
    input  logic             adv,
    output logic             valid,
    output logic             is_store,
    output stage_e           stage,
    output logic [LAT_W-1:0] lat
);
    logic             valid_n;
    logic             store_n;
    stage_e           stage_n;
    logic [LAT_W-1:0] lat_n;

    always_comb begin
        valid_n = valid;
        store_n = is_store;
        stage_n = stage;
        lat_n   = lat;
        if (ld_en) begin
            valid_n = ld_valid;
            store_n = ld_store;
            stage_n = ld_stage;
            lat_n   = ld_lat;
        end else if (valid) begin
            if (lat != '0) begin
                lat_n = lat - LAT_W'(1);
            end else if (adv) begin
                stage_n = next_stage(stage, is_store);
                lat_n   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            is_store <= 1'b0;
            stage    <= STG_FETCH;
            lat      <= '0;
        end else begin
            valid    <= valid_n;
            is_store <= store_n;
            stage    <= stage_n;
            lat      <= lat_n;
        end
    end

    // R2: a pending latency counts down with the stage held
    a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
        (valid && !ld_en && lat != '0) |=> (lat == $past(lat) - LAT_W'(1)) && $stable(stage));

    // R9: progress never goes backward without a load
    a_r9_no_regress: assert property (@(posedge clk) disable iff (rst)
        (valid && !ld_en) |=> stage_rank(stage) >= stage_rank($past(stage)));

    // R10: reset empties the slot
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> !valid);

    // R11: an empty slot stays empty until loaded
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!valid && !ld_en) |=> !valid);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
    import pac_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int LAT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSLOT-1:0]         ld_en,
    input  logic [NSLOT-1:0]         ld_valid,
    input  logic [NSLOT-1:0]         ld_store,
    input  logic [NSLOT*3-1:0]       ld_stage,
    input  logic [NSLOT*LAT_W-1:0]   ld_lat,
    input  logic [1:0]               sb_status,
    output logic [NSLOT-1:0]         slot_valid,
    output logic [NSLOT-1:0]         slot_store,
    output logic [NSLOT*3-1:0]       slot_stage,
    output logic [NSLOT*LAT_W-1:0]   slot_lat,
    output logic [NSLOT-1:0]         slot_adv
);
    localparam int SW = STAGE_W;

    sb_e              sb;
    logic             vld  [NSLOT];
    logic             sto  [NSLOT];
    stage_e           stg  [NSLOT];
    logic [LAT_W-1:0] lat  [NSLOT];
    logic             rdy  [NSLOT];
    logic             su_busy;
    logic             blk_load, blk_store, blk_shared;

    assign sb = sb_e'(sb_status);

    // Store stage occupancy over every slot.
    always_comb begin
        su_busy = 1'b0;
        for (int j = 0; j < NSLOT; j++) begin
            if (vld[j] && stg[j] == STG_STORE) su_busy = 1'b1;
        end
    end

    // A stage is blocked when any occupant is not ready this cycle.
    always_comb begin
        blk_load   = 1'b0;
        blk_store  = 1'b0;
        blk_shared = 1'b0;
        for (int j = 0; j < NSLOT; j++) begin
            if (vld[j] && !rdy[j]) begin
                case (stg[j])
                    STG_LOAD:   blk_load   = 1'b1;
                    STG_STORE:  blk_store  = 1'b1;
                    STG_SHARED: blk_shared = 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        stage_e tgt;
        logic   tgt_free;

        pac_ready #(.LAT_W(LAT_W)) u_rdy (
            .valid    (vld[i]),
            .is_store (sto[i]),
            .stage    (stg[i]),
            .lat      (lat[i]),
            .sb       (sb),
            .su_busy  (su_busy),
            .ready    (rdy[i])
        );

        always_comb begin
            tgt = next_stage(stg[i], sto[i]);
            unique case (tgt)
                STG_LOAD:   tgt_free = !blk_load;
                STG_STORE:  tgt_free = !blk_store;
                STG_SHARED: tgt_free = !blk_shared;
                default:    tgt_free = 1'b1;
            endcase
        end

        assign slot_adv[i] = rdy[i] && tgt_free;

        pac_slot #(.LAT_W(LAT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .ld_en    (ld_en[i]),
            .ld_valid (ld_valid[i]),
            .ld_store (ld_store[i]),
            .ld_stage (stage_e'(ld_stage[i*SW +: SW])),
            .ld_lat   (ld_lat[i*LAT_W +: LAT_W]),
            .adv      (slot_adv[i]),
            .valid    (vld[i]),
            .is_store (sto[i]),
            .stage    (stg[i]),
            .lat      (lat[i])
        );

        assign slot_valid[i]                  = vld[i];
        assign slot_store[i]                  = sto[i];
        assign slot_stage[i*SW +: SW]         = stg[i];
        assign slot_lat[i*LAT_W +: LAT_W]     = lat[i];

        // R3: a load leaves the shared stage only into a drained, idle store side
        a_r3_load_gate: assert property (@(posedge clk) disable iff (rst)
            (slot_adv[i] && !sto[i] && stg[i] == STG_SHARED)
                |-> (sb_status == 2'd0) && !su_busy);

        // R4: a store stage occupant leaves only with buffer room (R1: 2'b11 counts as full)
        a_r4_store_gate: assert property (@(posedge clk) disable iff (rst)
            (slot_adv[i] && stg[i] == STG_STORE) |-> (sb_status[1] == 1'b0));

        // R6: an advancing slot never enters a stage with a stalled occupant
        a_r6_target_free: assert property (@(posedge clk) disable iff (rst)
            (slot_adv[i] && tgt == STG_LOAD) |-> !blk_load);
    end
endmodule

// File: tb/pac_ctrl_test.sv
module pac_ctrl_test;
    localparam int NS = 4;
    localparam int LW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NS-1:0]   ld_en = '0;
    logic [NS-1:0]   ld_valid = '0;
    logic [NS-1:0]   ld_store = '0;
    logic [NS*3-1:0] ld_stage = '0;
    logic [NS*LW-1:0] ld_lat = '0;
    logic [1:0]      sb_status = 2'd0;
    logic [NS-1:0]   slot_valid, slot_store, slot_adv;
    logic [NS*3-1:0] slot_stage;
    logic [NS*LW-1:0] slot_lat;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of each slot
    int m_v [NS];
    int m_s [NS];
    int m_g [NS];
    int m_l [NS];
    int e_adv [NS];
    int e_tgt [NS];
    int m_sb;

    always #2.5 clk = ~clk;

    pac_ctrl #(.NSLOT(NS), .LAT_W(LW)) uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_valid(ld_valid),
        .ld_store(ld_store), .ld_stage(ld_stage), .ld_lat(ld_lat),
        .sb_status(sb_status), .slot_valid(slot_valid), .slot_store(slot_store),
        .slot_stage(slot_stage), .slot_lat(slot_lat), .slot_adv(slot_adv)
    );

    function automatic int rank(int g);
        if (g == 0) return 0;
        if (g == 3) return 1;
        if (g == 1 || g == 2) return 2;
        return 3;
    endfunction

    function automatic string tag_for(int i);
        if (m_v[i] == 0) return "R11";
        if (m_l[i] != 0) return "R2";
        if (m_g[i] == 3 && m_s[i] == 0) return "R3";
        if (m_g[i] == 2) return (m_sb == 3) ? "R1" : "R4";
        if (m_g[i] == 4) return "R5";
        return (e_adv[i] != 0) ? "R7" : "R6";
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_eval();
        int rdy [NS];
        int busy = 0;
        for (int j = 0; j < NS; j++) if (m_v[j] != 0 && m_g[j] == 2) busy = 1;
        for (int j = 0; j < NS; j++) begin
            rdy[j] = 0;
            if (m_v[j] != 0 && m_l[j] == 0) begin
                if (m_g[j] == 3) rdy[j] = (m_s[j] != 0) ? 1 : ((m_sb == 0 && busy == 0) ? 1 : 0);
                else if (m_g[j] == 2) rdy[j] = (m_sb < 2) ? 1 : 0;
                else if (m_g[j] <= 1) rdy[j] = 1;
            end
            if (m_g[j] == 0) e_tgt[j] = 3;
            else if (m_g[j] == 3) e_tgt[j] = (m_s[j] != 0) ? 2 : 1;
            else e_tgt[j] = 4;
        end
        for (int j = 0; j < NS; j++) begin
            int fr = 1;
            if (e_tgt[j] != 4)
                for (int k = 0; k < NS; k++)
                    if (m_v[k] != 0 && m_g[k] == e_tgt[j] && rdy[k] == 0) fr = 0;
            e_adv[j] = (rdy[j] != 0 && fr != 0) ? 1 : 0;
        end
    endtask

    task automatic set_slot(input int i, input int v, input int s, input int g, input int l);
        ld_en[i] = 1'b1;
        ld_valid[i] = v[0];
        ld_store[i] = s[0];
        ld_stage[i*3 +: 3] = g[2:0];
        ld_lat[i*LW +: LW] = l[LW-1:0];
        m_v[i] = v; m_s[i] = s; m_g[i] = g; m_l[i] = l;
    endtask

    // Called at a negedge after loads were driven: commits them.
    task automatic commit();
        @(negedge clk);
        ld_en = '0;
    endtask

    // One step: check flags, clock, check new state against the model.
    task automatic step_check();
        int old_rank [NS];
        #1;
        model_eval();
        for (int i = 0; i < NS; i++) begin
            check(tag_for(i), int'(slot_adv[i]), e_adv[i], $sformatf("adv slot %0d", i));
            old_rank[i] = rank(int'(slot_stage[i*3 +: 3]));
        end
        for (int i = 0; i < NS; i++) begin
            string t = tag_for(i);
            if (m_v[i] != 0) begin
                if (m_l[i] != 0) m_l[i] = m_l[i] - 1;
                else if (e_adv[i] != 0) m_g[i] = e_tgt[i];
            end
            e_tgt[i] = 0;
            e_adv[i] = 0;
            if (t == "") t = "R7";
        end
        @(negedge clk);
        #1;
        for (int i = 0; i < NS; i++) begin
            int act = int'({slot_valid[i], slot_store[i], slot_stage[i*3 +: 3], slot_lat[i*LW +: LW]});
            int exp = (m_v[i] << (4 + LW)) | (m_s[i] << (3 + LW)) | (m_g[i] << LW) | m_l[i];
            check((m_l[i] != 0 || m_v[i] == 0) ? "R2" : "R7", act, exp, $sformatf("state slot %0d", i));
            if (m_v[i] != 0)
                check("R9", (rank(int'(slot_stage[i*3 +: 3])) >= old_rank[i]) ? 1 : 0, 1,
                      $sformatf("rank slot %0d", i));
        end
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_s[i] = 0; m_g[i] = 0; m_l[i] = 0; end
        m_sb = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        check("R10", int'(slot_valid), 0, "valid after reset");
        check("R11", int'(slot_adv), 0, "adv after reset");

        // R2 / R7 / R3 / R5: one load walked through the pipeline
        @(negedge clk);
        set_slot(0, 1, 0, 0, 3);
        sb_status = 2'd1; m_sb = 1;
        commit();
        repeat (3) step_check();              // R2 countdown
        step_check();                         // R7 FETCH -> SHARED
        repeat (3) step_check();              // R3 held: buffer not empty
        check("R3", int'(slot_stage[2:0]), 3, "load held in shared stage");
        sb_status = 2'd0; m_sb = 0;
        step_check();                         // R7 SHARED -> LOAD
        step_check();                         // R7 LOAD -> RETIRED
        step_check();                         // R5 retired stays
        check("R5", int'(slot_stage[2:0]), 4, "retired slot stays");

        // R1: reserved code holds a store in the store stage
        set_slot(1, 1, 1, 2, 0);
        sb_status = 2'd3; m_sb = 3;
        commit();
        repeat (2) step_check();
        check("R1", int'(slot_stage[5:3]), 2, "store held under code 3");

        // R8: load overrides a pending advance
        sb_status = 2'd0; m_sb = 0;
        set_slot(1, 1, 1, 3, 1);
        commit();
        #1;
        check("R8", int'(slot_stage[5:3]), 3, "loaded stage");
        check("R8", int'(slot_lat[2*LW-1:LW]), 1, "loaded latency");

        // Sweep every slot combination under every buffer status.
        for (int sb = 0; sb < 4; sb++) begin
            for (int c = 0; c < 14641; c++) begin
                int code = c;
                sb_status = sb[1:0]; m_sb = sb;
                for (int i = 0; i < NS; i++) begin
                    int d = code % 11;
                    int l = ((c + i * 3) % 7 == 0) ? 1 : 0;
                    code = code / 11;
                    if (d == 10) set_slot(i, 0, 0, 0, 0);
                    else set_slot(i, 1, d & 1, d >> 1, l);
                end
                commit();
                step_check();
            end
        end

        // R10: synchronous reset in mid-flight
        set_slot(0, 1, 0, 1, 0);
        set_slot(2, 1, 1, 3, 2);
        commit();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", int'(slot_valid), 0, "valid after mid-run reset");
        for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_s[i] = 0; m_g[i] = 0; m_l[i] = 0; end
        step_check();                          // R11 idle slots stay idle

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule